// File: doc/BRIEF.md
# Single-Precision Float to Signed Word Converter

This block turns a 32-bit IEEE-754 single-precision operand into a two's-complement 32-bit integer, the way an integer-store step of a floating-point unit does. A 2-bit rounding field picks one of four rounding directions. All four share one datapath made of three stages:

- a field decoder that sorts the operand into a class;
- an aligner that places the significand on a fixed binary point and keeps a guard bit and a sticky bit;
- a rounder that applies the chosen direction, checks the range and forms the result and the flags.

One register stage captures the result. Every accepted operand gives exactly one result one clock later.

The decoder names five operand classes:

- `CL_ZERO`: exponent field zero, fraction zero.
- `CL_DENORM`: exponent field zero, fraction nonzero. The implied leading bit is 0.
- `CL_NORMAL`: exponent field neither zero nor all ones. The implied leading bit is 1.
- `CL_INF`: exponent field all ones, fraction zero.
- `CL_NAN`: exponent field all ones, fraction nonzero.

The block has no state machine. The only storage is the output register, which moves from empty to holding a result on each strobe.

An out-of-range or special operand raises the invalid flag. The integer returned in that case depends on a mask input. When the mask is set, the block returns the most negative integer as a stand-in value. When it is clear, it returns zero and leaves the fault to the surrounding logic.

Top module: `fti_convert`

## Requirements
- R1: The rounding field is decoded as follows: code 00 rounds to nearest, code 01 rounds toward minus infinity, code 10 rounds toward plus infinity and code 11 truncates toward zero. With code 00, a value halfway between two integers goes to the even one. So 5.64 gives 6, 2.5 gives 2, 3.5 gives 4, 1.5 gives 2 and -2.5 gives -2.
- R2: With code 01 the result is the largest integer not above the operand. So -1.2 gives -2 and 1.7 gives 1.
- R3: With code 10 the result is the smallest integer not below the operand. So 1.2 gives 2 and -1.7 gives -1.
- R4: With code 11 the fraction is dropped. So -1.7 gives -1 and 1.9 gives 1.
- R5: The inexact flag is 1 exactly when a valid result differs from the operand's value. It is always 0 when the invalid flag is 1.
- R6: An operand with an all-ones exponent field (infinity or NaN, either sign) sets the invalid flag.
- R7: A rounded value outside -2^31..2^31-1 sets the invalid flag. Exactly -2^31 (bits CF000000h) is valid and gives 80000000h with no flags.
- R8: When the invalid flag is 1, the integer output is 80000000h if the mask input is 1, and 0 if the mask input is 0.
- R9: Zeros of either sign give 0 with both flags clear. Denormals give 0 and set the inexact flag, except that code 01 rounds a negative denormal to -1 and code 10 rounds a positive denormal to +1. The inexact flag is set in those cases too.
- R10: `out_valid` equals `in_valid` delayed by one clock. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 32 | Single-precision operand |
| in_round | input | 2 | Rounding direction code |
| in_inv_mask | input | 1 | Selects the masked value for invalid results |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_int | output | 32 | Two's-complement integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Precision (inexact) flag |

## Verification
The assertions rely on a few properties of the inputs.

- `in_valid` is low through reset.
- The operand, rounding code and mask are stable, known values whenever the strobe is high. This lets the checks compare a registered output with the inputs of the cycle before.

The stimulus respects both by driving each field on the falling clock edge and holding it for a full cycle. It also sends every operand under all four rounding codes, so each class and every exponent range meets every direction. Those ranges are: below one half, exactly one half, integer, at the -2^31 boundary and beyond it.

// File: rtl/fti_pkg.sv
package fti_pkg;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_mode_t;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_DENORM,
        CL_NORMAL,
        CL_INF,
        CL_NAN
    } op_class_t;

endpackage

// File: rtl/fti_classify.sv
module fti_classify
    import fti_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]  op,
    output logic                   sign,
    output op_class_t              cls,
    output logic signed [EXP_W+1:0] exp_unb,
    output logic [FRAC_W:0]        sig
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic [EXP_W-1:0]  exp_fld;
    logic [FRAC_W-1:0] frac_fld;
    logic              exp_zero;
    logic              exp_ones;
    logic              frac_zero;

    assign sign     = op[EXP_W+FRAC_W];
    assign exp_fld  = op[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_fld = op[FRAC_W-1:0];
    assign exp_zero = (exp_fld == '0);
    assign exp_ones = (&exp_fld);
    assign frac_zero = (frac_fld == '0);

    // Unbiased exponent, two guard bits keep the sign safe
    assign exp_unb = $signed({2'b00, exp_fld}) - $signed((EXP_W+2)'(BIAS));

    always_comb begin
        if (exp_zero && frac_zero)      cls = CL_ZERO;
        else if (exp_zero)              cls = CL_DENORM;
        else if (exp_ones && frac_zero) cls = CL_INF;
        else if (exp_ones)              cls = CL_NAN;
        else                            cls = CL_NORMAL;
    end

    // Hidden leading bit is one only for normal operands
    assign sig = {(!exp_zero && !exp_ones), frac_fld};

endmodule

// File: rtl/fti_align.sv
module fti_align
    import fti_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32
) (
    input  op_class_t               cls,
    input  logic signed [EXP_W+1:0] exp_unb,
    input  logic [FRAC_W:0]         sig,
    output logic [INT_W-1:0]        mag,
    output logic                    guard,
    output logic                    sticky,
    output logic                    too_big
);
    // Fixed point: INT_W integer bits above INT_W fraction bits
    localparam int WIDE_W = 2 * INT_W;
    localparam int BASE   = INT_W - FRAC_W;

    logic [WIDE_W-1:0]       wide;
    logic signed [EXP_W+1:0] shamt;

    assign shamt = exp_unb + $signed((EXP_W+2)'(BASE));

    always_comb begin
        mag     = '0;
        guard   = 1'b0;
        sticky  = 1'b0;
        too_big = 1'b0;
        wide    = '0;
        unique case (cls)
            CL_ZERO: begin
            end
            CL_DENORM: begin
                // Far below one half: only sticky survives
                sticky = 1'b1;
            end
            CL_NORMAL: begin
                if (exp_unb >= INT_W) begin
                    too_big = 1'b1;
                end else if (exp_unb < -1) begin
                    sticky = 1'b1;
                end else begin
                    wide   = {{(WIDE_W-FRAC_W-1){1'b0}}, sig} << unsigned'(shamt);
                    mag    = wide[WIDE_W-1:INT_W];
                    guard  = wide[INT_W-1];
                    sticky = |wide[INT_W-2:0];
                end
            end
            CL_INF, CL_NAN: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/fti_round.sv
module fti_round
    import fti_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             sign,
    input  rnd_mode_t        mode,
    input  op_class_t        cls,
    input  logic [INT_W-1:0] mag,
    input  logic             guard,
    input  logic             sticky,
    input  logic             too_big,
    input  logic             inv_mask,
    output logic [INT_W-1:0] res,
    output logic             invalid,
    output logic             inexact
);
    localparam logic [INT_W:0]   POS_LIM = (INT_W+1)'((64'd1 << (INT_W - 1)) - 64'd1);
    localparam logic [INT_W:0]   NEG_LIM = (INT_W+1)'(64'd1 << (INT_W - 1));
    localparam logic [INT_W-1:0] MIN_INT = {1'b1, {(INT_W-1){1'b0}}};

    logic             lost;
    logic             bump;
    logic [INT_W:0]   mag_r;
    logic             range_bad;
    logic             special;

    assign lost = guard | sticky;

    always_comb begin
        unique case (mode)
            RND_NEAR: bump = guard & (sticky | mag[0]);
            RND_DOWN: bump = sign & lost;
            RND_UP:   bump = ~sign & lost;
            RND_ZERO: bump = 1'b0;
            default:  bump = 1'b0;
        endcase
    end

    assign mag_r     = {1'b0, mag} + {{INT_W{1'b0}}, bump};
    assign range_bad = too_big | (sign ? (mag_r > NEG_LIM) : (mag_r > POS_LIM));
    assign special   = (cls == CL_INF) || (cls == CL_NAN);

    always_comb begin
        if (special || range_bad) begin
            invalid = 1'b1;
            inexact = 1'b0;
            res     = inv_mask ? MIN_INT : '0;
        end else begin
            invalid = 1'b0;
            inexact = lost;
            res     = sign ? (~mag_r[INT_W-1:0] + 1'b1) : mag_r[INT_W-1:0];
        end
    end

endmodule

// File: rtl/fti_convert.sv
module fti_convert
    import fti_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [EXP_W+FRAC_W:0]  in_operand,
    input  logic [1:0]             in_round,
    input  logic                   in_inv_mask,
    output logic                   out_valid,
    output logic [INT_W-1:0]       out_int,
    output logic                   out_invalid,
    output logic                   out_inexact
);
    localparam int OP_W = EXP_W + FRAC_W + 1;

    logic                    sgn;
    op_class_t               cls;
    logic signed [EXP_W+1:0] exp_unb;
    logic [FRAC_W:0]         sig;
    logic [INT_W-1:0]        mag;
    logic                    guard;
    logic                    sticky;
    logic                    too_big;
    logic [INT_W-1:0]        res_c;
    logic                    inv_c;
    logic                    inx_c;

    fti_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .op      (in_operand),
        .sign    (sgn),
        .cls     (cls),
        .exp_unb (exp_unb),
        .sig     (sig)
    );

    fti_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
        .cls     (cls),
        .exp_unb (exp_unb),
        .sig     (sig),
        .mag     (mag),
        .guard   (guard),
        .sticky  (sticky),
        .too_big (too_big)
    );

    fti_round #(.INT_W(INT_W)) u_round (
        .sign     (sgn),
        .mode     (rnd_mode_t'(in_round)),
        .cls      (cls),
        .mag      (mag),
        .guard    (guard),
        .sticky   (sticky),
        .too_big  (too_big),
        .inv_mask (in_inv_mask),
        .res      (res_c),
        .invalid  (inv_c),
        .inexact  (inx_c)
    );

    // Result register: strobe always, data only on an accepted operand
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_int     <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_int     <= res_c;
                out_invalid <= inv_c;
                out_inexact <= inx_c;
            end
        end
    end

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    a_r6_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_operand[OP_W-2:FRAC_W])) |=> out_invalid);

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));

    a_r8_masked_value: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid && $past(in_inv_mask))
            |-> (out_int == {1'b1, {(INT_W-1){1'b0}}}));

    a_r9_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_operand[OP_W-2:0] == '0))
            |=> (out_int == '0 && !out_invalid && !out_inexact));

endmodule

// File: tb/test_fti_convert.sv
module test_fti_convert;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic [1:0]  in_round = '0;
    logic        in_inv_mask = 1'b0;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_invalid;
    logic        out_inexact;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [31:0] op;
        logic [1:0]  mode;
        logic [31:0] val;
        logic        inv;
        logic        inx;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];

    always #4 clk = ~clk;

    fti_convert i_fti_convert (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .in_round    (in_round),
        .in_inv_mask (in_inv_mask),
        .out_valid   (out_valid),
        .out_int     (out_int),
        .out_invalid (out_invalid),
        .out_inexact (out_inexact)
    );

    // Independent reference: decode to real, round with floor
    function automatic void model(input logic [31:0] b, input logic [1:0] m,
                                  input logic mask, output exp_t e);
        real v, f, fr, q;
        int  ex;
        bit  odd;
        e.op = b; e.mode = m; e.inv = 1'b0; e.inx = 1'b0; e.val = '0;
        if (&b[30:23]) begin
            e.inv = 1'b1;
            e.val = mask ? 32'h8000_0000 : 32'h0;
            return;
        end
        ex = int'(b[30:23]);
        if (ex == 0) v = real'(b[22:0]) * (2.0 ** (-149));
        else         v = (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** (ex - 127));
        if (b[31]) v = -v;
        f  = $floor(v);
        fr = v - f;
        odd = ((f / 2.0) != $floor(f / 2.0));
        case (m)
            2'b00:   q = (fr > 0.5 || (fr == 0.5 && odd)) ? f + 1.0 : f;
            2'b01:   q = f;
            2'b10:   q = (fr != 0.0) ? f + 1.0 : f;
            default: q = (v < 0.0 && fr != 0.0) ? f + 1.0 : f;
        endcase
        if (q > 2147483647.0 || q < -2147483648.0) begin
            e.inv = 1'b1;
            e.val = mask ? 32'h8000_0000 : 32'h0;
        end else begin
            e.val = 32'(longint'(q));
            e.inx = (q != v);
        end
    endfunction

    task automatic send(input logic [31:0] b, input logic [1:0] m,
                        input logic mask, input string tag);
        exp_t e;
        @(negedge clk);
        model(b, m, mask, e);
        expq.push_back(e);
        tagq.push_back(tag);
        in_valid    = 1'b1;
        in_operand  = b;
        in_round    = m;
        in_inv_mask = mask;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            0:       return "R1";
            1:       return "R2";
            2:       return "R3";
            default: return "R4";
        endcase
    endfunction

    // Monitor: compare each result with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R10: result strobe with nothing outstanding, got %h expected none", out_int);
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                n_cmp++;
                if (out_int !== e.val || out_invalid !== e.inv || out_inexact !== e.inx) begin
                    n_bad++;
                    $display("FAIL %s (R5 flags): op %h mode %0d got int %h inv %0b inx %0b expected int %h inv %0b inx %0b",
                             t, e.op, e.mode, out_int, out_invalid, out_inexact, e.val, e.inv, e.inx);
                end
            end
        end
    end

    task automatic all_modes(input logic [31:0] b, input string tag);
        for (int m = 0; m < 4; m++) begin
            send(b, 2'(m), 1'b1, (tag == "") ? mode_tag(m) : tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;
        // R10 reset state
        if (out_valid !== 1'b0 || out_int !== 32'h0 || out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: reset outputs got %b %h %b %b expected 0 0 0 0",
                     out_valid, out_int, out_invalid, out_inexact);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 nearest-even and the rounding code decode; R2 R3 R4 directed
        send(32'h40B4_7AE1, 2'b00, 1'b1, "R1");   // 5.64 -> 6
        all_modes(32'h4020_0000, "");              // 2.5
        all_modes(32'h4060_0000, "");              // 3.5
        all_modes(32'hC020_0000, "");              // -2.5
        all_modes(32'h3FC0_0000, "");              // 1.5
        all_modes(32'h3F00_0000, "");              // 0.5
        all_modes(32'h3F99_999A, "");              // 1.2
        all_modes(32'hBF99_999A, "");              // -1.2
        all_modes(32'h3FD9_999A, "");              // 1.7
        all_modes(32'hBFD9_999A, "");              // -1.7
        all_modes(32'h3FF3_3333, "");              // 1.9
        all_modes(32'h3E99_999A, "");              // 0.3
        all_modes(32'hBE99_999A, "");              // -0.3
        // R5 exact values leave the precision flag clear
        all_modes(32'h42C8_0000, "R5");            // 100.0
        all_modes(32'hC0E0_0000, "R5");            // -7.0
        all_modes(32'h4EFF_FFFF, "R5");            // 2147483520
        // R6 specials, both mask settings (R8)
        all_modes(32'h7F80_0000, "R6");
        all_modes(32'hFF80_0000, "R6");
        all_modes(32'h7FC0_0000, "R6");
        all_modes(32'h7F80_0001, "R6");
        send(32'h7FC0_0000, 2'b00, 1'b0, "R8");
        send(32'hFF80_0000, 2'b11, 1'b0, "R8");
        // R7 range edges
        all_modes(32'hCF00_0000, "R7");            // -2^31 valid
        all_modes(32'h4F00_0000, "R7");            // 2^31 invalid
        all_modes(32'hCF00_0001, "R7");
        all_modes(32'h5380_0000, "R7");
        send(32'h4F00_0000, 2'b00, 1'b0, "R8");
        // R9 zeros and denormals
        all_modes(32'h0000_0000, "R9");
        all_modes(32'h8000_0000, "R9");
        all_modes(32'h0000_0001, "R9");
        all_modes(32'h8000_0001, "R9");
        all_modes(32'h007F_FFFF, "R9");
        all_modes(32'h807F_FFFF, "R9");
        idle();
        // R10 gap then a single strobe
        repeat (3) @(negedge clk);
        send(32'h40B4_7AE1, 2'b11, 1'b1, "R10");
        idle();
        repeat (4) @(negedge clk);
        n_cmp++;
        if (expq.size() != 0) begin
            n_bad++;
            $display("FAIL R10: %0d results missing, expected 0", expq.size());
        end
        finished = 1'b1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (200000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL R10: watchdog expired, got hang expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule